// File: doc/BRIEF.md
# Board Control Register with Parity Error Capture

This block holds the control and status word of a network adapter board together with a small set of registers that record a memory parity failure. A host reaches all of it through a 16-bit register port with a two-bit register select. Writes take effect on the next clock. Reads are combinational on the select. Three bits of the control word directly drive the network controller's reset line, its channel-attention strobe and its loopback/on-air select. A fourth bit enables the expansion bus.

The block merges two interrupt sources onto one host interrupt line, each through its own enable. The first source is the controller's interrupt input, which is mirrored as a read-only flag. The second is a parity-error flag owned by the block. When the memory parity checker reports a failure, the block freezes the 20-bit failing address, the source indicator and the byte-end indicator. These values stay frozen until the host writes an acknowledge. Read-only configuration inputs report the RAM device size and bits 17 to 20 of the RAM base address.

Register select encoding: 0 is the control/status word, 1 is parity control, 2 is the low half of the failing address, and 3 is unused.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, every writable control bit and the parity flag are 0. All control outputs and the host interrupt are low.
- R2: A write to register 0 loads the writable bits from the next cycle on: bit 15 reset, bit 14 on-air, bit 13 attention, bit 12 controller interrupt enable, bit 11 parity interrupt enable, bit 5 expansion bus enable. `ctl_reset_o`, `on_air_o`, `ctl_attn_o` and `xbus_en_o` follow bits 15, 14, 13 and 5, and hold until the next write.
- R3: Register 0 reads as follows. Bit 9 is the parity flag. Bit 8 is the level of `ctl_irq_i`. Bit 4 is `ram_256k_i`. Bits 3:0 are `ram_base_i`. Bits 10, 7 and 6 read 0. Write data on the read-only bits has no effect.
- R4: If `par_err_i` is high in a cycle where the parity flag is clear, the next cycle has the flag set and the captured fields loaded. Register 2 then holds the failing address bits 15:0. Register 1 holds address bits 19:16 in bits 3:0, the source in bit 7 and the byte end in bit 6.
- R5: While the parity flag is set and no acknowledge is written, further parity errors leave the captured address, source and end unchanged.
- R6: A write to register 1 with bit 8 = 1 clears the parity flag on the next cycle. The captured fields keep their values.
- R7: When an acknowledge and a parity error fall in the same cycle, the new error wins. The flag stays set and the fields capture the new error.
- R8: `host_irq_o` is high exactly when (the controller interrupt input AND the bit 12 enable) OR (the parity flag AND the bit 11 enable). It responds in the same cycle as its inputs.
- R9: Writes to register 1 that do not set bit 8 have no effect, and neither do writes to registers 2 and 3. Register 1 bit 8 always reads 0. Register 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ctl_irq_i | input | 1 | Controller interrupt request level |
| par_err_i | input | 1 | Parity error report, one per high cycle |
| par_addr_i | input | 20 | Failing address of the reported error |
| par_src_i | input | 1 | Source of the reported error |
| par_end_i | input | 1 | Byte end of the reported error |
| ram_base_i | input | 4 | RAM base address bits 17 to 20 |
| ram_256k_i | input | 1 | RAM device size indicator |
| ctl_reset_o | output | 1 | Controller reset |
| ctl_attn_o | output | 1 | Channel attention |
| on_air_o | output | 1 | On-air select (0 selects loopback) |
| xbus_en_o | output | 1 | Expansion bus enable |
| host_irq_o | output | 1 | Combined host interrupt |

## Verification
Two events can land in the same clock: the host's acknowledge write and a fresh parity error from the memory. The bench provokes this in two ways. It places an acknowledge directly under a new error report with a different address. It also lets a random phase drive both inputs freely. A behavioural reference model judges each clock and expects the flag to stay set with the new address captured. Checks that read registers 1 and 2 afterwards separate the "error wins" outcome from a lost error and from a stale capture.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int PA_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ctl_irq_i,
  input  logic        par_err_i,
  input  logic [19:0] par_addr_i,
  input  logic        par_src_i,
  input  logic        par_end_i,
  input  logic [3:0]  ram_base_i,
  input  logic        ram_256k_i,
  output logic        ctl_reset_o,
  output logic        ctl_attn_o,
  output logic        on_air_o,
  output logic        xbus_en_o,
  output logic        host_irq_o
);
  localparam int HI_W = PA_W - 16;

  logic            st_rst, st_air, st_attn, st_ien, st_pien, st_xbus;
  logic            pflag, cap_src, cap_end;
  logic [PA_W-1:0] cap_addr;

  wire wr_st = reg_wr && (reg_addr == 2'd0);
  wire ack   = reg_wr && (reg_addr == 2'd1) && reg_wdata[8];
  wire take  = par_err_i && (!pflag || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rst  <= 1'b0;
      st_air  <= 1'b0;
      st_attn <= 1'b0;
      st_ien  <= 1'b0;
      st_pien <= 1'b0;
      st_xbus <= 1'b0;
    end else if (wr_st) begin
      st_rst  <= reg_wdata[15];
      st_air  <= reg_wdata[14];
      st_attn <= reg_wdata[13];
      st_ien  <= reg_wdata[12];
      st_pien <= reg_wdata[11];
      st_xbus <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pflag    <= 1'b0;
      cap_src  <= 1'b0;
      cap_end  <= 1'b0;
      cap_addr <= '0;
    end else if (take) begin
      pflag    <= 1'b1;
      cap_src  <= par_src_i;
      cap_end  <= par_end_i;
      cap_addr <= par_addr_i[PA_W-1:0];
    end else if (ack) begin
      pflag    <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata = {st_rst, st_air, st_attn, st_ien, st_pien, 1'b0, pflag,
                         ctl_irq_i, 2'b00, st_xbus, ram_256k_i, ram_base_i};
      2'd1: begin
        reg_rdata[7]      = cap_src;
        reg_rdata[6]      = cap_end;
        reg_rdata[HI_W-1:0] = cap_addr[PA_W-1:16];
      end
      2'd2: reg_rdata = cap_addr[15:0];
      default: reg_rdata = '0;
    endcase
  end

  assign ctl_reset_o = st_rst;
  assign ctl_attn_o  = st_attn;
  assign on_air_o    = st_air;
  assign xbus_en_o   = st_xbus;
  assign host_irq_o  = (ctl_irq_i & st_ien) | (pflag & st_pien);
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      reg_addr,
  input logic            reg_wr,
  input logic [15:0]     reg_wdata,
  input logic [15:0]     reg_rdata,
  input logic            par_err_i,
  input logic [19:0]     par_addr_i,
  input logic            pflag,
  input logic [PA_W-1:0] cap_addr,
  input logic            st_ien,
  input logic            ctl_reset_o,
  input logic            host_irq_o
);
  wire hack = reg_wr && (reg_addr == 2'd1) && reg_wdata[8];

  p_reset_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (ctl_reset_o == $past(reg_wdata[15])));

  p_gap_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[10] == 1'b0 && reg_rdata[7:6] == 2'b00));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pflag && par_err_i) |=> (pflag && cap_addr == $past(par_addr_i[PA_W-1:0])));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag && !hack) |=> (pflag && $stable(cap_addr)));

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag && hack && !par_err_i) |=> !pflag);

  p_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag && hack && par_err_i) |=> (pflag && cap_addr == $past(par_addr_i[PA_W-1:0])));

  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ien && !pflag) |-> !host_irq_o);
endmodule

bind board_ctl_regs board_ctl_regs_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .par_err_i(par_err_i),
  .par_addr_i(par_addr_i), .pflag(pflag), .cap_addr(cap_addr),
  .st_ien(st_ien), .ctl_reset_o(ctl_reset_o), .host_irq_o(host_irq_o));

// File: tb/tb_board_ctl_regs.sv
module tb_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ctl_irq_i = 1'b0;
  logic        par_err_i = 1'b0;
  logic [19:0] par_addr_i = '0;
  logic        par_src_i = 1'b0;
  logic        par_end_i = 1'b0;
  logic [3:0]  ram_base_i = 4'h6;
  logic        ram_256k_i = 1'b1;
  logic        ctl_reset_o, ctl_attn_o, on_air_o, xbus_en_o, host_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit        m_rst, m_air, m_attn, m_ien, m_pien, m_xbus, m_pf, m_src, m_end;
  bit [19:0] m_addr;

  always #5 clk = ~clk;

  board_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_irq_i(ctl_irq_i),
    .par_err_i(par_err_i), .par_addr_i(par_addr_i), .par_src_i(par_src_i),
    .par_end_i(par_end_i), .ram_base_i(ram_base_i), .ram_256k_i(ram_256k_i),
    .ctl_reset_o(ctl_reset_o), .ctl_attn_o(ctl_attn_o), .on_air_o(on_air_o),
    .xbus_en_o(xbus_en_o), .host_irq_o(host_irq_o));

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit [15:0] exp_rdata();
    bit [15:0] v = '0;
    case (reg_addr)
      2'd0: begin
        v[15] = m_rst; v[14] = m_air; v[13] = m_attn; v[12] = m_ien; v[11] = m_pien;
        v[9] = m_pf; v[8] = ctl_irq_i; v[5] = m_xbus; v[4] = ram_256k_i; v[3:0] = ram_base_i;
      end
      2'd1: begin v[7] = m_src; v[6] = m_end; v[3:0] = m_addr[19:16]; end
      2'd2: v = m_addr[15:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step(input string tag);
    bit ack, take;
    #1;
    check(tag, "rdata", int'(reg_rdata), int'(exp_rdata()));
    check(tag, "reset", int'(ctl_reset_o), int'(m_rst));
    check(tag, "attn", int'(ctl_attn_o), int'(m_attn));
    check(tag, "onair", int'(on_air_o), int'(m_air));
    check(tag, "xbus", int'(xbus_en_o), int'(m_xbus));
    check(tag, "irq", int'(host_irq_o), int'((ctl_irq_i && m_ien) || (m_pf && m_pien)));
    ack  = reg_wr && reg_addr == 2'd1 && reg_wdata[8];
    take = par_err_i && (!m_pf || ack);
    @(posedge clk);
    if (reg_wr && reg_addr == 2'd0) begin
      m_rst = reg_wdata[15]; m_air = reg_wdata[14]; m_attn = reg_wdata[13];
      m_ien = reg_wdata[12]; m_pien = reg_wdata[11]; m_xbus = reg_wdata[5];
    end
    if (take) begin
      m_pf = 1'b1; m_addr = par_addr_i; m_src = par_src_i; m_end = par_end_i;
    end else if (ack) m_pf = 1'b0;
    #1;
  endtask

  task automatic put(input bit wr, input bit [1:0] a, input bit [15:0] d);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
  endtask

  task automatic perr(input bit e, input bit [19:0] a, input bit s, input bit en);
    par_err_i = e; par_addr_i = a; par_src_i = s; par_end_i = en;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    put(0, 0, 0); step("R1"); step("R1");
    put(0, 1, 0); step("R1");
    put(0, 2, 0); step("R1");
    put(0, 3, 0); step("R9");

    put(1, 0, 16'hFFFF); step("R2");
    put(0, 0, 0); step("R3");
    ram_base_i = 4'h9; ram_256k_i = 1'b0; step("R3");
    put(1, 0, 16'h2000); step("R2");
    put(1, 0, 16'h0000); step("R2");
    put(0, 0, 0); step("R2");
    put(1, 0, 16'h8020); step("R2");
    put(0, 0, 0); step("R2"); step("R2");
    put(1, 0, 16'h1000); step("R8");
    put(0, 0, 0); ctl_irq_i = 1'b1; step("R8"); step("R3");
    put(1, 0, 16'h0800); step("R8");
    put(0, 0, 0); step("R8");
    ctl_irq_i = 1'b0;

    perr(1, 20'hABCDE, 1, 0); step("R4");
    perr(0, 0, 0, 0); step("R8");
    put(0, 1, 0); step("R4");
    put(0, 2, 0); step("R4");
    perr(1, 20'h12345, 0, 1); step("R5");
    perr(0, 0, 0, 0); put(0, 1, 0); step("R5");
    put(0, 2, 0); step("R5");
    put(1, 1, 16'hFEFF); step("R9");
    put(1, 2, 16'h5555); step("R9");
    put(1, 3, 16'hFFFF); step("R9");
    put(0, 0, 0); step("R9");
    put(0, 1, 0); step("R9");
    put(1, 1, 16'h0100); step("R6");
    put(0, 0, 0); step("R6");
    put(0, 2, 0); step("R6");

    perr(1, 20'h0F0F0, 0, 0); step("R4");
    perr(1, 20'h76543, 1, 1); put(1, 1, 16'h0100); step("R7");
    perr(0, 0, 0, 0); put(0, 0, 0); step("R7");
    put(0, 1, 0); step("R7");
    put(0, 2, 0); step("R7");

    for (int i = 0; i < 400; i++) begin
      reg_wr     = ($urandom_range(0, 3) == 0);
      reg_addr   = 2'($urandom_range(0, 3));
      reg_wdata  = 16'($urandom);
      ctl_irq_i  = 1'($urandom);
      par_err_i  = ($urandom_range(0, 4) == 0);
      par_addr_i = 20'($urandom);
      par_src_i  = 1'($urandom);
      par_end_i  = 1'($urandom);
      step("R7");
    end

    put(0, 0, 0); perr(0, 0, 0, 0);
    rst_n = 1'b0;
    m_rst = 0; m_air = 0; m_attn = 0; m_ien = 0; m_pien = 0; m_xbus = 0;
    m_pf = 0; m_src = 0; m_end = 0; m_addr = '0;
    #1; step("R1");
    rst_n = 1'b1; step("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule